// File: doc/BRIEF.md
# Content-Addressable Match Array

This block is a small content-addressable memory. It holds a set of data words, by default four words of four bits each. On each clock cycle it does one of three things. It can stay idle. It can store a word into one entry chosen by an index. It can search, which compares a key against every stored word in the same cycle.

A search result has three parts: a flag that says exactly one entry matched, a flag that says two or more entries matched, and the index of the matching entry. When several entries match, the lowest index is reported. Entries have no valid qualifier. After reset every entry holds zero, and those entries take part in searches like any other.

The results are registered. A search presented before a clock edge produces its result just after that edge. The result holds until the next edge, where the next operation replaces it. Callers such as a translation lookup treat the single-hit flag as a usable hit and the multiple-hit flag as an error condition.

Top module: `cam_match_array`

## Requirements
- R1: After reset every entry holds zero, and `hit_one_o`, `hit_many_o` and `hit_addr_o` are all zero.
- R2: With `en_i` and `wr_i` both high at a clock edge, `data_i` is stored in the entry selected by `addr_i`. After that edge both flags are low and `hit_addr_o` is zero.
- R3: After a search edge, `hit_one_o` is high only when exactly one entry equals the key. It is low on a miss, and low when two or more entries match.
- R4: After a search edge, `hit_many_o` is high exactly when two or more entries equal the key.
- R5: On any hit, `hit_addr_o` is the lowest index among the matching entries. For example, with entries 1 and 2 holding 5 and entry 0 holding 4, a search for 5 returns index 1.
- R6: A search is performed when `en_i` is high and `wr_i` is low. Its result appears on the outputs after the first clock edge at which it is presented, and it lasts for one cycle only.
- R7: A search that matches no entry gives both flags low and `hit_addr_o` zero.
- R8: With `en_i` low, both flags are low and `hit_addr_o` is zero after the edge. `wr_i`, `addr_i` and `data_i` are ignored, so no entry changes.
- R9: Entries have no valid qualifier. A search for zero right after reset therefore reports a multiple match at index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Operation enable |
| wr_i | input | 1 | High: store; low: search (when enabled) |
| addr_i | input | 2 | Entry index for a store |
| data_i | input | 4 | Word to store, or search key |
| hit_one_o | output | 1 | Exactly one entry matched |
| hit_many_o | output | 1 | Two or more entries matched |
| hit_addr_o | output | 2 | Lowest matching entry index, zero on miss |

## Verification
A corrupted or dropped store does not show up at the outputs right away. It appears only when a later search uses the affected value. That search then shows a missing hit, a single hit where a multiple hit is expected, or a wrong index. The error appears one cycle after the search is presented. A fault in the match-count or priority logic appears on the very first search that exercises the affected case. For this reason the directed scenarios search for values held by zero, one and two entries. The random phase repeats these cases against a reference copy of the array.

// File: rtl/cam_pkg.sv
package cam_pkg;

   typedef enum logic [1:0] {
      CAM_IDLE   = 2'd0,
      CAM_STORE  = 2'd1,
      CAM_SEARCH = 2'd2
   } cam_op_e;

   function automatic cam_op_e cam_decode(input logic en, input logic wr);
      if (!en)     return CAM_IDLE;
      else if (wr) return CAM_STORE;
      else         return CAM_SEARCH;
   endfunction

endpackage

// File: rtl/cam_store.sv
module cam_store #(
   parameter int ENTRIES = 4,
   parameter int WIDTH   = 4,
   localparam int ADDR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [WIDTH-1:0]                wr_data,
   output logic [ENTRIES-1:0][WIDTH-1:0]   entries_o
);

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               entries_o[e] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(e)))
               entries_o[e] <= wr_data;
         end
      end
   endgenerate

   // R2: a store lands in the addressed entry
   a_r2_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> entries_o[$past(wr_addr)] == $past(wr_data));

   // R8: without a store, entries hold
   a_r8_entries_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(entries_o));

endmodule

// File: rtl/cam_compare.sv
module cam_compare #(
   parameter int ENTRIES = 4,
   parameter int WIDTH   = 4
) (
   input  logic [ENTRIES-1:0][WIDTH-1:0] entries_i,
   input  logic [WIDTH-1:0]              key_i,
   output logic [ENTRIES-1:0]            hits_o
);

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
         assign hits_o[e] = (entries_i[e] == key_i);
      end
   endgenerate

endmodule

// File: rtl/cam_encode.sv
module cam_encode #(
   parameter int ENTRIES = 4,
   localparam int ADDR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
   input  logic [ENTRIES-1:0] hits_i,
   output logic               one_o,
   output logic               many_o,
   output logic [ADDR_W-1:0]  addr_o
);

   logic [CNT_W-1:0] count;

   always_comb begin
      count = '0;
      for (int i = 0; i < ENTRIES; i++)
         count = count + CNT_W'(hits_i[i]);
   end

   // lowest index wins: scan downward so the last assignment is the lowest
   always_comb begin
      addr_o = '0;
      for (int i = ENTRIES - 1; i >= 0; i--)
         if (hits_i[i]) addr_o = ADDR_W'(i);
   end

   assign one_o  = (count == CNT_W'(1));
   assign many_o = (count >  CNT_W'(1));

endmodule

// File: rtl/cam_match_array.sv
module cam_match_array #(
   parameter int ENTRIES = 4,
   parameter int WIDTH   = 4,
   localparam int ADDR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [WIDTH-1:0]  data_i,
   output logic              hit_one_o,
   output logic              hit_many_o,
   output logic [ADDR_W-1:0] hit_addr_o
);
   import cam_pkg::*;

   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("cam_match_array: ENTRIES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("cam_match_array: WIDTH must be at least 1");
      end
   endgenerate

   cam_op_e                        op;
   logic [ENTRIES-1:0][WIDTH-1:0]  entries;
   logic [ENTRIES-1:0]             hits;
   logic                           enc_one, enc_many;
   logic [ADDR_W-1:0]              enc_addr;

   assign op = cam_decode(en_i, wr_i);

   cam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (op == CAM_STORE),
      .wr_addr   (addr_i),
      .wr_data   (data_i),
      .entries_o (entries)
   );

   cam_compare #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_cmp (
      .entries_i (entries),
      .key_i     (data_i),
      .hits_o    (hits)
   );

   cam_encode #(.ENTRIES(ENTRIES)) u_enc (
      .hits_i (hits),
      .one_o  (enc_one),
      .many_o (enc_many),
      .addr_o (enc_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_one_o  <= 1'b0;
         hit_many_o <= 1'b0;
         hit_addr_o <= '0;
      end else if (op == CAM_SEARCH) begin
         hit_one_o  <= enc_one;
         hit_many_o <= enc_many;
         hit_addr_o <= enc_addr;
      end else begin
         hit_one_o  <= 1'b0;
         hit_many_o <= 1'b0;
         hit_addr_o <= '0;
      end
   end

   // R3/R4: single and multiple flags never both high
   a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_one_o && hit_many_o));

   // R7: no flag means index zero
   a_r7_miss_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_one_o && !hit_many_o) |-> hit_addr_o == '0);

   // R2: a store cycle reports nothing
   a_r2_store_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && wr_i) |=> (!hit_one_o && !hit_many_o && hit_addr_o == '0));

   // R8: disabled cycle reports nothing
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!hit_one_o && !hit_many_o && hit_addr_o == '0));

   // R5/R6: key equal to entry 0 gives a hit at index 0 after the edge
   a_r5_entry0_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !wr_i && entries[0] == data_i)
         |=> ((hit_one_o || hit_many_o) && hit_addr_o == '0));

endmodule

// File: tb/cam_match_array_test.sv
`timescale 1ns/1ps
module cam_match_array_test;

   localparam int ENTRIES = 4;
   localparam int WIDTH   = 4;
   localparam int ADDR_W  = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              en_i = 1'b0;
   logic              wr_i = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic [WIDTH-1:0]  data_i = '0;
   logic              hit_one_o, hit_many_o;
   logic [ADDR_W-1:0] hit_addr_o;

   int checks = 0;
   int failures = 0;
   logic [WIDTH-1:0] model [ENTRIES];

   always #2 clk = ~clk;

   cam_match_array #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) uut (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .wr_i(wr_i),
      .addr_i(addr_i), .data_i(data_i),
      .hit_one_o(hit_one_o), .hit_many_o(hit_many_o), .hit_addr_o(hit_addr_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_outs(input string req, input logic one, input logic many, input int addr);
      check(req, "hit_one_o",  int'(hit_one_o),  int'(one));
      check(req, "hit_many_o", int'(hit_many_o), int'(many));
      check(req, "hit_addr_o", int'(hit_addr_o), addr);
   endtask

   // one operation: drive at negedge, sample at next negedge (after one posedge)
   task automatic step(input string req, input logic en, input logic wr,
                       input int a, input int d);
      int cnt;
      int low;
      logic e_one, e_many;
      int e_addr;
      @(negedge clk);
      en_i = en; wr_i = wr; addr_i = ADDR_W'(a); data_i = WIDTH'(d);
      cnt = 0; low = -1;
      if (en && !wr) begin
         for (int i = 0; i < ENTRIES; i++)
            if (model[i] == WIDTH'(d)) begin
               cnt++;
               if (low < 0) low = i;
            end
      end
      e_one  = (cnt == 1);
      e_many = (cnt >= 2);
      e_addr = (cnt > 0) ? low : 0;
      @(negedge clk);
      check_outs(req, e_one, e_many, e_addr);
      if (en && wr) model[a] = WIDTH'(d);
      en_i = 1'b0; wr_i = 1'b0;
   endtask

   task automatic t_reset;
      for (int i = 0; i < ENTRIES; i++) model[i] = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_outs("R1", 1'b0, 1'b0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_outs("R1", 1'b0, 1'b0, 0);
   endtask

   task automatic t_zero_after_reset;
      step("R9", 1, 0, 0, 0);              // all four zero entries match
      check("R9", "many_expected", int'(hit_many_o), 1);
   endtask

   task automatic t_idle_and_miss;
      step("R8", 0, 0, 0, 0);              // disabled: would match but no report
      step("R7", 1, 0, 0, 1);              // key 1 matches nothing
   endtask

   task automatic t_store_then_single;
      step("R2", 1, 1, 0, 4);
      step("R3", 1, 0, 0, 4);              // only entry 0 holds 4
      check("R3", "single_expected", int'(hit_one_o), 1);
      step("R7", 1, 0, 2, 5);
   endtask

   task automatic t_result_lasts_one_cycle;
      step("R6", 1, 0, 0, 4);              // hit visible right after edge
      step("R6", 0, 0, 0, 4);              // gone the next cycle
   endtask

   task automatic t_multiple;
      step("R2", 1, 1, 1, 5);
      step("R2", 1, 1, 2, 5);
      step("R4", 1, 0, 3, 5);              // entries 1 and 2 -> many, index 1
      check("R5", "lowest_index", int'(hit_addr_o), 1);
      step("R5", 1, 0, 0, 0);              // only entry 3 still zero
      check("R5", "entry3", int'(hit_addr_o), 3);
   endtask

   task automatic t_disabled_store_ignored;
      step("R8", 0, 1, 0, 7);              // must not write entry 0
      step("R8", 1, 0, 0, 7);              // 7 absent
      step("R8", 1, 0, 0, 4);              // entry 0 still 4
      check("R8", "entry0_kept", int'(hit_one_o), 1);
   endtask

   task automatic t_random;
      for (int n = 0; n < 400; n++) begin
         int a, d;
         logic en, wr;
         a  = int'($urandom_range(0, ENTRIES - 1));
         d  = int'($urandom_range(0, 3));
         en = ($urandom_range(0, 7) != 0);
         wr = ($urandom_range(0, 2) == 0);
         step("R5", en, wr, a, d);
      end
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_zero_after_reset();
            t_idle_and_miss();
            t_store_then_single();
            t_result_lasts_one_cycle();
            t_multiple();
            t_disabled_store_ignored();
            t_random();
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            failures++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule